// File: doc/BRIEF.md
# Vector mask logic unit

This block takes one 32-bit vector instruction word together with the operand data it needs and computes the result of a mask-register operation. The operands are two source masks, the v0 mask, the prior contents of the destination, and the active length `vl`. Decode and execution are fused. The unit recognises its own instruction family and raises one of two flags for any word it cannot run. If the word belongs to another family, it raises the foreign flag. If the word is a malformed member of this family, it raises the illegal flag.

The supported operations fall into three groups:
- Eight bitwise combinations of two masks.
- A population count and a find-lowest-set-bit, both of which return a scalar.
- Three prefix transforms that mark the positions before, up to and including, or exactly at the first active set bit.

Positions at or above `vl` take no part in an operation and are passed through from the old destination value. The same holds for positions that v0 disables in a masked operation.

The unit accepts one operation per cycle when `in_valid` is high. All results are registered, and `out_valid` pulses exactly one cycle after the accept. `out_is_scalar` tells the consumer which result to use: the scalar or the destination mask.

Top module: `vmask_unit`

## Requirements
- R1: A word is handled only when bits 6:0 equal 1010111 and bits 14:12 equal 010. Any other word returns `out_unhandled`=1 with `out_illegal`=0 and zero results.
- R2: The function is selected by bits 31:26. With bit 25 (vm) = 1, the values 011000 through 011111 select, in that order, `a & ~b`, `a & b`, `a | b`, `a ^ b`, `a | ~b`, `~(a & b)`, `~(a | b)` and `~(a ^ b)`. Here `a` is `src_a` and `b` is `src_b`. The result is written as a mask.
- R3: A word that selects a bitwise function (bits 31:26 in 011000..011111) with bit 25 = 0 is flagged illegal.
- R4: Bits 31:26 = 010000 with bits 19:15 = 10000 return the number of active set bits of `src_a` as a scalar. `out_is_scalar`=1 and `out_mask`=0.
- R5: Bits 31:26 = 010000 with bits 19:15 = 10001 return the index of the lowest active set bit of `src_a`. If no active bit is set, the scalar is all ones.
- R6: Bits 31:26 = 010100 select a prefix transform through bits 19:15:
  - 00001: set every position below the first active set bit.
  - 00011: set every position up to and including the first active set bit.
  - 00010: set only the first active set bit.
- R7: When bit 25 = 0, only positions whose v0 bit is 1 are active for the count, find, and transform operations. Destination bits at inactive positions keep their value from `dst_old`.
- R8: Positions at or above `vl` are never active. Their destination bits equal `dst_old` for every mask-producing operation.
- R9: Under 010000 or 010100, any other value in bits 19:15 is flagged illegal. The same applies to any other value of bits 31:26 inside the family. An illegal word produces zero mask, zero scalar and `out_is_scalar`=0.
- R10: `in_ready` is high out of reset. `out_valid` is high in exactly the cycle after an accepted word, and the result appears in that cycle.
- R11: During and right after reset, `out_valid`, the flags, `out_mask` and `out_scalar` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word and operands are present |
| in_ready | output | 1 | Unit can take a word |
| instr | input | 32 | Instruction word |
| src_a | input | VLEN | Mask selected by bits 24:20 |
| src_b | input | VLEN | Mask selected by bits 19:15 |
| mask_v0 | input | VLEN | v0 enable mask |
| dst_old | input | VLEN | Prior destination contents |
| vl | input | $clog2(VLEN+1) | Active length |
| out_valid | output | 1 | Result cycle |
| out_unhandled | output | 1 | Word is outside this family |
| out_illegal | output | 1 | Malformed word in this family |
| out_is_scalar | output | 1 | Scalar result rather than mask |
| out_scalar | output | XLEN | Count or index result |
| out_mask | output | VLEN | Destination mask result |

## Verification
An 8-bit configuration is swept exhaustively over `src_a` for every function. `src_b`, v0 and the old destination are derived from `src_a` as scrambled patterns, so each bitwise function sees every input pairing across the sweep.

`vl` takes three values: 0, a partial length and the full width. Each transform and each scalar operation runs both masked and unmasked. This separates three effects: tail pass-through, pass-through at inactive positions, and the change in the first active bit when v0 hides a lower set bit. The all-zero `src_a` sweep point distinguishes the -1 return of the find operation.

A set of foreign, malformed and excluded sub-codes shows that the two flags are kept apart and that no result leaks through.

// File: rtl/mlu_pkg.sv
package mlu_pkg;

    localparam logic [6:0] MAJOR_OPC = 7'b1010111;
    localparam logic [2:0] MINOR_F3  = 3'b010;
    localparam logic [5:0] GRP_SCAL  = 6'b010000;
    localparam logic [5:0] GRP_XFRM  = 6'b010100;
    localparam logic [2:0] GRP_LOGIC_HI = 3'b011;
    localparam logic [4:0] SUB_POP   = 5'b10000;
    localparam logic [4:0] SUB_FIRST = 5'b10001;
    localparam logic [4:0] SUB_BEFORE = 5'b00001;
    localparam logic [4:0] SUB_ONLY   = 5'b00010;
    localparam logic [4:0] SUB_UPTO   = 5'b00011;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOGIC,
        OP_POP,
        OP_FIRST,
        OP_BEFORE,
        OP_UPTO,
        OP_ONLY
    } mop_e;

    // Encoding order matters: it follows the low three bits of the selector.
    typedef enum logic [2:0] {
        LF_ANDNOT,
        LF_AND,
        LF_OR,
        LF_XOR,
        LF_ORNOT,
        LF_NAND,
        LF_NOR,
        LF_XNOR
    } lfn_e;

    typedef struct packed {
        logic foreign;
        logic illegal;
        mop_e op;
        lfn_e lfn;
        logic vm;
    } mdec_t;

    function automatic mdec_t decode_word(input logic [31:0] w);
        mdec_t d;
        logic [5:0] sel;
        logic [4:0] sub;
        sel = w[31:26];
        sub = w[19:15];
        d.foreign = 1'b0;
        d.illegal = 1'b0;
        d.op      = OP_NONE;
        d.lfn     = LF_ANDNOT;
        d.vm      = w[25];
        if (w[6:0] != MAJOR_OPC || w[14:12] != MINOR_F3) begin
            d.foreign = 1'b1;
        end else if (sel[5:3] == GRP_LOGIC_HI) begin
            if (w[25]) begin
                d.op  = OP_LOGIC;
                d.lfn = lfn_e'(sel[2:0]);
            end else begin
                d.illegal = 1'b1;
            end
        end else if (sel == GRP_SCAL) begin
            case (sub)
                SUB_POP:   d.op = OP_POP;
                SUB_FIRST: d.op = OP_FIRST;
                default:   d.illegal = 1'b1;
            endcase
        end else if (sel == GRP_XFRM) begin
            case (sub)
                SUB_BEFORE: d.op = OP_BEFORE;
                SUB_UPTO:   d.op = OP_UPTO;
                SUB_ONLY:   d.op = OP_ONLY;
                default:    d.illegal = 1'b1;
            endcase
        end else begin
            d.illegal = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/mlu_lanes.sv
module mlu_lanes #(
    parameter int VLEN = 64,
    localparam int VLW = $clog2(VLEN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [VLW-1:0]  vl,
    input  logic [VLEN-1:0] v0,
    input  logic            vm,
    output logic [VLEN-1:0] in_vl,
    output logic [VLEN-1:0] on
);

    for (genvar g = 0; g < VLEN; g++) begin : g_lane
        assign in_vl[g] = (vl > VLW'(g));
        assign on[g]    = in_vl[g] & (vm | v0[g]);
    end

    a_r7_active_inside_vl: assert property (@(posedge clk) disable iff (rst)
        (on & ~in_vl) == '0);

    a_r8_prefix_shape: assert property (@(posedge clk) disable iff (rst)
        (in_vl & ~(in_vl >> 1) & ~(in_vl << 1) & ~in_vl) == '0 &&
        (((in_vl >> 1) & ~in_vl)) == '0);

endmodule

// File: rtl/mlu_logic.sv
module mlu_logic
    import mlu_pkg::*;
#(
    parameter int VLEN = 64
) (
    input  lfn_e            fn,
    input  logic [VLEN-1:0] a,
    input  logic [VLEN-1:0] b,
    output logic [VLEN-1:0] y
);

    always_comb begin
        case (fn)
            LF_ANDNOT: y = a & ~b;
            LF_AND:    y = a & b;
            LF_OR:     y = a | b;
            LF_XOR:    y = a ^ b;
            LF_ORNOT:  y = a | ~b;
            LF_NAND:   y = ~(a & b);
            LF_NOR:    y = ~(a | b);
            default:   y = ~(a ^ b);
        endcase
    end

endmodule

// File: rtl/mlu_scan.sv
module mlu_scan #(
    parameter int VLEN = 64,
    localparam int LVLS = $clog2(VLEN),
    localparam int CW   = $clog2(VLEN + 1),
    localparam int IW   = (LVLS < 1) ? 1 : LVLS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [VLEN-1:0] src,
    output logic [VLEN-1:0] incl,
    output logic [CW-1:0]   pop,
    output logic [IW-1:0]   first,
    output logic            found
);

    // Log-depth inclusive prefix OR, one stage per doubling distance.
    logic [VLEN-1:0] stage [0:LVLS];
    assign stage[0] = src;

    for (genvar k = 0; k < LVLS; k++) begin : g_lvl
        for (genvar i = 0; i < VLEN; i++) begin : g_bit
            if (i >= (1 << k)) begin : g_join
                assign stage[k+1][i] = stage[k][i] | stage[k][i - (1 << k)];
            end else begin : g_pass
                assign stage[k+1][i] = stage[k][i];
            end
        end
    end

    assign incl  = stage[LVLS];
    assign found = incl[VLEN-1];

    always_comb begin
        pop = '0;
        for (int i = 0; i < VLEN; i++) begin
            pop = pop + CW'(src[i]);
        end
    end

    always_comb begin
        first = '0;
        for (int i = VLEN - 1; i >= 0; i--) begin
            if (src[i]) first = IW'(i);
        end
    end

    a_r5_first_is_lowest: assert property (@(posedge clk) disable iff (rst)
        found |-> (src[first] && ((src & ((VLEN'(1) << first) - VLEN'(1))) == '0)));

    a_r4_pop_zero_iff_none: assert property (@(posedge clk) disable iff (rst)
        (pop == '0) == !found);

    a_r6_prefix_monotone: assert property (@(posedge clk) disable iff (rst)
        ((incl << 1) & ~incl) == '0);

endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
    import mlu_pkg::*;
#(
    parameter int VLEN = 64,
    parameter int XLEN = 64,
    localparam int VLW = $clog2(VLEN + 1),
    localparam int CW  = $clog2(VLEN + 1),
    localparam int IW  = ($clog2(VLEN) < 1) ? 1 : $clog2(VLEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      instr,
    input  logic [VLEN-1:0]  src_a,
    input  logic [VLEN-1:0]  src_b,
    input  logic [VLEN-1:0]  mask_v0,
    input  logic [VLEN-1:0]  dst_old,
    input  logic [VLW-1:0]   vl,
    output logic             out_valid,
    output logic             out_unhandled,
    output logic             out_illegal,
    output logic             out_is_scalar,
    output logic [XLEN-1:0]  out_scalar,
    output logic [VLEN-1:0]  out_mask
);

    typedef struct packed {
        logic            unhandled;
        logic            illegal;
        logic            is_scalar;
        logic [XLEN-1:0] scalar;
        logic [VLEN-1:0] mask;
    } mres_t;

    mdec_t           dec;
    logic            accept;
    logic [VLEN-1:0] in_vl, on, lres, src, incl, excl, xf, sof_v;
    logic [CW-1:0]   pop;
    logic [IW-1:0]   first;
    logic            found;
    mres_t           nxt, cur;

    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;

    always_comb dec = decode_word(instr);

    mlu_lanes #(.VLEN(VLEN)) u_lanes (
        .clk(clk), .rst(rst), .vl(vl), .v0(mask_v0), .vm(dec.vm),
        .in_vl(in_vl), .on(on)
    );

    mlu_logic #(.VLEN(VLEN)) u_logic (
        .fn(dec.lfn), .a(src_a), .b(src_b), .y(lres)
    );

    assign src = src_a & on;

    mlu_scan #(.VLEN(VLEN)) u_scan (
        .clk(clk), .rst(rst), .src(src),
        .incl(incl), .pop(pop), .first(first), .found(found)
    );

    assign excl  = {incl[VLEN-2:0], 1'b0};
    assign sof_v = src & ~excl;

    always_comb begin
        case (dec.op)
            OP_BEFORE: xf = ~incl;
            OP_UPTO:   xf = ~excl;
            default:   xf = sof_v;
        endcase
    end

    always_comb begin
        nxt           = '0;
        nxt.unhandled = dec.foreign;
        nxt.illegal   = dec.illegal;
        if (!dec.foreign && !dec.illegal) begin
            case (dec.op)
                OP_LOGIC: nxt.mask = (lres & in_vl) | (dst_old & ~in_vl);
                OP_POP: begin
                    nxt.is_scalar = 1'b1;
                    nxt.scalar    = XLEN'(pop);
                end
                OP_FIRST: begin
                    nxt.is_scalar = 1'b1;
                    nxt.scalar    = found ? XLEN'(first) : '1;
                end
                OP_BEFORE, OP_UPTO, OP_ONLY:
                    nxt.mask = (xf & on) | (dst_old & ~on);
                default: nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            cur       <= '0;
        end else begin
            out_valid <= accept;
            if (accept) cur <= nxt;
        end
    end

    assign out_unhandled = cur.unhandled;
    assign out_illegal   = cur.illegal;
    assign out_is_scalar = cur.is_scalar;
    assign out_scalar    = cur.scalar;
    assign out_mask      = cur.mask;

    a_r10_accept_then_valid: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !out_valid);

    a_r1_foreign_no_result: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_unhandled) |-> (!out_illegal && out_mask == '0 && out_scalar == '0));

    a_r9_illegal_no_result: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_mask == '0 && out_scalar == '0 && !out_is_scalar));

    a_r6_only_first_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sof_v));

    a_r8_tail_passthrough: assert property (@(posedge clk) disable iff (rst)
        (accept && !dec.foreign && !dec.illegal && dec.op != OP_POP && dec.op != OP_FIRST)
        |=> ((out_mask & ~$past(in_vl)) == ($past(dst_old) & ~$past(in_vl))));

endmodule

// File: tb/vmask_unit_tb.sv
`timescale 1ns/1ps
module vmask_unit_tb;

    localparam int VLEN = 8;
    localparam int XLEN = 16;
    localparam int VLW  = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic            in_ready;
    logic [31:0]     instr;
    logic [VLEN-1:0] src_a, src_b, mask_v0, dst_old;
    logic [VLW-1:0]  vl;
    logic            out_valid, out_unhandled, out_illegal, out_is_scalar;
    logic [XLEN-1:0] out_scalar;
    logic [VLEN-1:0] out_mask;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    vmask_unit #(.VLEN(VLEN), .XLEN(XLEN)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .instr(instr), .src_a(src_a), .src_b(src_b), .mask_v0(mask_v0),
        .dst_old(dst_old), .vl(vl), .out_valid(out_valid),
        .out_unhandled(out_unhandled), .out_illegal(out_illegal),
        .out_is_scalar(out_is_scalar), .out_scalar(out_scalar), .out_mask(out_mask)
    );

    function automatic logic [31:0] mkw(input logic [5:0] sel, input logic [4:0] sub,
                                        input logic vmb);
        return {sel, vmb, 5'd2, sub, 3'b010, 5'd1, 7'b1010111};
    endfunction

    // kind: 0 bitwise, 1 count, 2 first, 3 before, 4 up-to, 5 only
    function automatic void model(input int kind, input int lf, input logic vmb,
                                  input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                                  input logic [VLEN-1:0] v0, input logic [VLEN-1:0] old,
                                  input int len, output logic [VLEN-1:0] em,
                                  output logic [XLEN-1:0] es, output logic esc);
        logic seen;
        int   cnt;
        int   fi;
        seen = 1'b0; cnt = 0; fi = -1;
        em = '0; es = '0; esc = (kind == 1 || kind == 2);
        for (int i = 0; i < VLEN; i++) begin
            logic inr, act, cur, r;
            inr = (i < len);
            act = inr && (vmb || v0[i]);
            cur = act && a[i];
            case (lf)
                0: r = a[i] & ~b[i];
                1: r = a[i] & b[i];
                2: r = a[i] | b[i];
                3: r = a[i] ^ b[i];
                4: r = a[i] | ~b[i];
                5: r = ~(a[i] & b[i]);
                6: r = ~(a[i] | b[i]);
                default: r = ~(a[i] ^ b[i]);
            endcase
            case (kind)
                0: em[i] = inr ? r : old[i];
                3: em[i] = act ? !(seen || cur) : old[i];
                4: em[i] = act ? !seen : old[i];
                5: em[i] = act ? (cur && !seen) : old[i];
                default: em[i] = 1'b0;
            endcase
            if (cur) begin
                cnt++;
                if (fi < 0) fi = i;
            end
            seen = seen || cur;
        end
        if (kind == 1) es = XLEN'(cnt);
        if (kind == 2) es = (fi < 0) ? '1 : XLEN'(fi);
    endfunction

    task automatic drive(input logic [31:0] w, input logic [VLEN-1:0] a,
                         input logic [VLEN-1:0] b, input logic [VLEN-1:0] v0,
                         input logic [VLEN-1:0] old, input int len);
        @(negedge clk);
        in_valid = 1'b1; instr = w; src_a = a; src_b = b;
        mask_v0 = v0; dst_old = old; vl = VLW'(len);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input string tag, input logic eu, input logic ei, input logic esc,
                         input logic [XLEN-1:0] es, input logic [VLEN-1:0] em);
        n_tests++;
        if (out_valid !== 1'b1 || out_unhandled !== eu || out_illegal !== ei ||
            out_is_scalar !== esc || out_scalar !== es || out_mask !== em) begin
            n_fail++;
            $display("FAIL %s: actual v=%b u=%b i=%b s=%b sc=%h m=%h expected v=1 u=%b i=%b s=%b sc=%h m=%h",
                     tag, out_valid, out_unhandled, out_illegal, out_is_scalar, out_scalar,
                     out_mask, eu, ei, esc, es, em);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] em;
        logic [XLEN-1:0] es;
        logic            esc;
        rst = 1'b1; in_valid = 1'b0; instr = '0; src_a = '0; src_b = '0;
        mask_v0 = '0; dst_old = '0; vl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state, R10 ready out of reset
        n_tests++;
        if (out_valid !== 1'b0 || out_unhandled !== 1'b0 || out_illegal !== 1'b0 ||
            out_mask !== '0 || out_scalar !== '0 || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R11: actual v=%b m=%h s=%h rdy=%b expected v=0 m=0 s=0 rdy=1",
                     out_valid, out_mask, out_scalar, in_ready);
        end

        // R2 R8: bitwise functions, every src_a value, three lengths
        for (int lf = 0; lf < 8; lf++) begin
            for (int av = 0; av < 256; av++) begin
                for (int li = 0; li < 3; li++) begin
                    logic [VLEN-1:0] a, b, v0, old;
                    int len;
                    len = (li == 0) ? 0 : (li == 1) ? 5 : 8;
                    a = VLEN'(av);
                    b = {a[3:0], a[7:4]} ^ 8'h3C ^ VLEN'(lf);
                    v0 = 8'hC9 ^ (a >> 1);
                    old = ~a ^ 8'hA5;
                    drive(mkw({3'b011, 3'(lf)}, 5'(av), 1'b1), a, b, v0, old, len);
                    model(0, lf, 1'b1, a, b, v0, old, len, em, es, esc);
                    check("R2 R8", 1'b0, 1'b0, esc, es, em);
                end
            end
        end

        // R4 R5 R6 R7 R8: scalar ops and transforms, masked and unmasked
        for (int kind = 1; kind < 6; kind++) begin
            for (int av = 0; av < 256; av++) begin
                for (int li = 0; li < 3; li++) begin
                    for (int m = 0; m < 2; m++) begin
                        logic [VLEN-1:0] a, v0, old;
                        logic [5:0] sel;
                        logic [4:0] sub;
                        int len;
                        len = (li == 0) ? 0 : (li == 1) ? 5 : 8;
                        a = VLEN'(av);
                        v0 = 8'b1011_0110 ^ {a[0], a[7:1]};
                        old = 8'h5A ^ {a[6:0], a[7]};
                        sel = (kind <= 2) ? 6'b010000 : 6'b010100;
                        case (kind)
                            1: sub = 5'b10000;
                            2: sub = 5'b10001;
                            3: sub = 5'b00001;
                            4: sub = 5'b00011;
                            default: sub = 5'b00010;
                        endcase
                        drive(mkw(sel, sub, m[0]), a, 8'hFF, v0, old, len);
                        model(kind, 0, m[0], a, 8'hFF, v0, old, len, em, es, esc);
                        case (kind)
                            1: check("R4 R7 R8", 1'b0, 1'b0, esc, es, em);
                            2: check("R5 R7 R8", 1'b0, 1'b0, esc, es, em);
                            default: check("R6 R7 R8", 1'b0, 1'b0, esc, es, em);
                        endcase
                    end
                end
            end
        end

        // R1: foreign words
        drive(32'h0000_0017 | (32'd2 << 12), 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8);
        check("R1 opcode", 1'b1, 1'b0, 1'b0, '0, '0);
        drive(mkw(6'b011001, 5'd3, 1'b1) & ~32'h0000_7000, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8);
        check("R1 minor", 1'b1, 1'b0, 1'b0, '0, '0);

        // R3: bitwise with vm cleared
        for (int lf = 0; lf < 8; lf++) begin
            drive(mkw({3'b011, 3'(lf)}, 5'd4, 1'b0), 8'hF0, 8'h0F, 8'hFF, 8'h33, 8);
            check("R3", 1'b0, 1'b1, 1'b0, '0, '0);
        end

        // R9: other sub-codes and selectors
        drive(mkw(6'b010000, 5'b00000, 1'b1), 8'hFF, 8'h00, 8'hFF, 8'h33, 8);
        check("R9 scal sub", 1'b0, 1'b1, 1'b0, '0, '0);
        drive(mkw(6'b010100, 5'b10000, 1'b1), 8'hFF, 8'h00, 8'hFF, 8'h33, 8);
        check("R9 xfrm 10000", 1'b0, 1'b1, 1'b0, '0, '0);
        drive(mkw(6'b010100, 5'b10001, 1'b0), 8'hFF, 8'h00, 8'hFF, 8'h33, 8);
        check("R9 xfrm 10001", 1'b0, 1'b1, 1'b0, '0, '0);
        drive(mkw(6'b010100, 5'b00100, 1'b1), 8'hFF, 8'h00, 8'hFF, 8'h33, 8);
        check("R9 xfrm 00100", 1'b0, 1'b1, 1'b0, '0, '0);
        drive(mkw(6'b000000, 5'b10000, 1'b1), 8'hFF, 8'h00, 8'hFF, 8'h33, 8);
        check("R9 selector", 1'b0, 1'b1, 1'b0, '0, '0);

        // R10: idle cycle gives no valid
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 idle: actual v=%b expected v=0", out_valid);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule